// File: doc/BRIEF.md
# Charge-Pump Fast-Lock Window Timer

This block times the fast-lock interval of a synthesizer loop. Each time a new divider word is committed, the controller pulses `rf_load`. The block then opens a speedup window whose length is the 7-bit setting `tm_set` multiplied by 64 reference-clock cycles. During the window it can raise the charge-pump high-current select `cp_fast` and the gate of the open-drain loop-filter bypass switch `fsw_gate`. When the window closes, both outputs fall back to the steady-state (low-current, switch open) condition.

Each output has its own disable. `boost_en` low keeps the charge pump at low current. `sw_hold` high keeps the filter switch open. Both settings, and the timer value, are captured on the load pulse. A sleep input for the RF section overrides everything and cancels any running window. The pins are plain level controls with no flow control, because no data stream crosses this block.

Top module: `pll_speedup_timer`

## Requirements
- R1: After `rf_load` is sampled high on a clock edge with `tm_set` = T (1 to 127), the window is open for exactly 64*T clock cycles, starting with the cycle that follows that edge. The window is built from a 6-bit prescaler that wraps at 64 and a 7-bit down-counter.
- R2: If `boost_en` was 0 at the load, `cp_fast` stays 0 for the whole window.
- R3: If `boost_en` was 1 at the load, `cp_fast` is 1 for every cycle of the window and 0 once it closes.
- R4: If `sw_hold` was 0 at the load, `fsw_gate` is 1 for every cycle of the window. If `sw_hold` was 1, `fsw_gate` stays 0.
- R5: `tm_set`, `boost_en` and `sw_hold` take effect only on a load. Changing them while a window runs does not change its length or its outputs.
- R6: A load that arrives during a running window restarts timing from zero with the new setting. The combined high time is therefore the gap between the two loads plus 64*T.
- R7: A load with `tm_set` = 0 opens no window, and it closes any window that is already running from the next cycle.
- R8: While `rf_sleep` is 1, both outputs are 0 in the same cycle and the running window is cancelled. Loads seen during sleep are ignored, so no window appears after sleep ends.
- R9: After reset, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rf_load | input | 1 | One-cycle pulse marking a new divider word |
| tm_set | input | 7 | Window length in units of 64 clocks |
| boost_en | input | 1 | 1 = high current during the window |
| sw_hold | input | 1 | 1 = filter switch held open |
| rf_sleep | input | 1 | RF section power-save; forces the window off |
| cp_fast | output | 1 | Charge-pump high-current select |
| fsw_gate | output | 1 | Open-drain filter switch gate |

## Verification
The bench measures whole window lengths in clock cycles for T = 1, 4 and 127, where an off-by-one prescaler or counter would show up as 63 or 65 cycles per unit. It restarts a window mid-run and cancels one with T = 0. A design that kept the old count, or ignored the zero setting, would report the wrong combined length. It changes the settings mid-window and raises sleep mid-window, then pulses load during sleep. Sampling the settings live, or letting a load slip past sleep, would produce a wrong or unexpected window.

// File: rtl/spd_pkg.sv
package spd_pkg;
  localparam int unsigned PRE_W = 6;
  localparam int unsigned TM_W  = 7;

  typedef struct packed {
    logic boost;
    logic hold;
  } spd_cfg_t;
endpackage

// File: rtl/spd_prescale.sv
module spd_prescale #(
  parameter int unsigned W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam logic [W-1:0] LAST = {W{1'b1}};

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (run)    cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);

  a_r1_prescale_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && cnt == LAST) |=> (cnt == '0));
  a_r1_prescale_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(cnt));
endmodule

// File: rtl/spd_downcount.sv
module spd_downcount #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  input  logic         kill,
  output logic         active
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (kill) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (load) begin
      cnt    <= load_val;
      active <= (load_val != '0);
    end else if (active && tick) begin
      cnt <= cnt - 1'b1;
      if (cnt == {{(W-1){1'b0}}, 1'b1}) active <= 1'b0;
    end
  end

  a_r7_zero_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !kill && load_val == '0) |=> !active);
  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !kill && load_val != '0) |=> (active && cnt == $past(load_val)));
  a_r1_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick && !load && !kill) |=> (active && $stable(cnt)));
  a_r1_last_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (active && tick && cnt == 1 && !load && !kill) |=> !active);
  a_r8_kill: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !active);
endmodule

// File: rtl/spd_outgate.sv
module spd_outgate
  import spd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     capture,
  input  spd_cfg_t cfg_in,
  input  logic     active,
  input  logic     sleep,
  output logic     cp_fast,
  output logic     fsw_gate
);
  spd_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cfg_q <= '0;
    else if (capture) cfg_q <= cfg_in;
  end

  always_comb begin
    cp_fast  = active && !sleep && cfg_q.boost;
    fsw_gate = active && !sleep && !cfg_q.hold;
  end

  a_r5_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(cfg_q));
  a_r2_no_boost: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.boost |-> !cp_fast);
  a_r4_switch_held: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.hold |-> !fsw_gate);
  a_r8_sleep_off: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (!cp_fast && !fsw_gate));
endmodule

// File: rtl/pll_speedup_timer.sv
module pll_speedup_timer
  import spd_pkg::*;
#(
  parameter int unsigned PRE_BITS = PRE_W,
  parameter int unsigned TM_BITS  = TM_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rf_load,
  input  logic [TM_BITS-1:0] tm_set,
  input  logic               boost_en,
  input  logic               sw_hold,
  input  logic               rf_sleep,
  output logic               cp_fast,
  output logic               fsw_gate
);
  logic     load_ok;
  logic     tick;
  logic     win_active;
  spd_cfg_t cfg_in;

  assign load_ok = rf_load && !rf_sleep;
  assign cfg_in  = '{boost: boost_en, hold: sw_hold};

  spd_prescale #(.W(PRE_BITS)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (load_ok || rf_sleep),
    .run   (win_active),
    .tick  (tick)
  );

  spd_downcount #(.W(TM_BITS)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_ok),
    .load_val (tm_set),
    .tick     (tick),
    .kill     (rf_sleep),
    .active   (win_active)
  );

  spd_outgate u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .capture  (load_ok),
    .cfg_in   (cfg_in),
    .active   (win_active),
    .sleep    (rf_sleep),
    .cp_fast  (cp_fast),
    .fsw_gate (fsw_gate)
  );

  a_r9_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!cp_fast && !fsw_gate));
  a_r8_sleep_load_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_sleep && rf_load) |=> !win_active);
endmodule

// File: tb/test_pll_speedup_timer.sv
module test_pll_speedup_timer;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       rf_load = 0;
  logic [6:0] tm_set = 0;
  logic       boost_en = 0;
  logic       sw_hold = 0;
  logic       rf_sleep = 0;
  logic       cp_fast;
  logic       fsw_gate;

  int n_checks = 0;
  int n_fail = 0;
  int tot_hi = 0;
  int tot_sw = 0;

  typedef struct {
    int    len;
    bit    hi;
    bit    sw;
    string tag;
  } win_t;
  win_t exp_q[$];

  always #2 clk = ~clk;

  pll_speedup_timer i_pll_speedup_timer (
    .clk(clk), .rst_n(rst_n), .rf_load(rf_load), .tm_set(tm_set),
    .boost_en(boost_en), .sw_hold(sw_hold), .rf_sleep(rf_sleep),
    .cp_fast(cp_fast), .fsw_gate(fsw_gate)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: measures each window and compares it with the scoreboard entry.
  int run_len = 0, run_hi = 0, run_sw = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (cp_fast) tot_hi++;
      if (fsw_gate) tot_sw++;
      if (cp_fast || fsw_gate) begin
        run_len++;
        if (cp_fast) run_hi++;
        if (fsw_gate) run_sw++;
      end else if (run_len > 0) begin
        if (exp_q.size() == 0) begin
          chk(0, "R7/R8 unexpected window", run_len, 0);
        end else begin
          win_t w;
          w = exp_q.pop_front();
          chk(run_len == w.len, {w.tag, " R1 window length"}, run_len, w.len);
          chk(run_hi == (w.hi ? w.len : 0), {w.tag, " R2/R3 cp_fast cycles"}, run_hi, w.hi ? w.len : 0);
          chk(run_sw == (w.sw ? w.len : 0), {w.tag, " R4 fsw_gate cycles"}, run_sw, w.sw ? w.len : 0);
        end
        run_len = 0; run_hi = 0; run_sw = 0;
      end
    end
  end

  // One load pulse; returns 1 ns after the edge that samples it.
  task automatic pulse(input int tm, input bit en, input bit hold);
    @(posedge clk); #1;
    rf_load = 1; tm_set = 7'(tm); boost_en = en; sw_hold = hold;
    @(posedge clk); #1;
    rf_load = 0;
  endtask

  task automatic expect_win(input int len, input bit en, input bit hold, input string tag);
    win_t w;
    w.len = len; w.hi = en; w.sw = !hold; w.tag = tag;
    exp_q.push_back(w);
  endtask

  task automatic settle(input int cyc);
    repeat (cyc) @(posedge clk);
    #1;
  endtask

  initial begin
    int h0, s0;
    settle(3);
    chk(cp_fast == 0, "R9 cp_fast in reset", cp_fast, 0);
    chk(fsw_gate == 0, "R9 fsw_gate in reset", fsw_gate, 0);
    rst_n = 1;
    settle(3);
    chk(!cp_fast && !fsw_gate, "R9 idle after reset", cp_fast | fsw_gate, 0);

    // R1/R3/R4: shortest window
    expect_win(64, 1, 0, "T=1");
    pulse(1, 1, 0); settle(64 + 20);
    // R3 with switch held (R4)
    expect_win(256, 1, 1, "T=4 hold");
    pulse(4, 1, 1); settle(256 + 20);
    // R2: longest window, no boost
    expect_win(8128, 0, 0, "T=127 noboost");
    pulse(127, 0, 0); settle(8128 + 20);
    // R2+R4: both disabled -> nothing visible
    h0 = tot_hi; s0 = tot_sw;
    pulse(4, 0, 1); settle(256 + 20);
    chk(tot_hi == h0 && tot_sw == s0, "R2/R4 both disabled", tot_hi + tot_sw - h0 - s0, 0);
    // R5: inputs change mid-window
    expect_win(128, 1, 0, "R5 frozen cfg");
    pulse(2, 1, 0);
    tm_set = 100; boost_en = 0; sw_hold = 1;
    settle(128 + 20);
    // R6: restart during window (gap 50 -> loads 52 cycles apart)
    expect_win(52 + 192, 1, 0, "R6 restart");
    pulse(3, 1, 0); settle(50); pulse(3, 1, 0); settle(192 + 20);
    // R7: zero setting alone
    h0 = tot_hi; s0 = tot_sw;
    pulse(0, 1, 0); settle(100);
    chk(tot_hi == h0 && tot_sw == s0, "R7 T=0 no window", tot_hi + tot_sw - h0 - s0, 0);
    // R7: zero setting cancels running window
    expect_win(22, 1, 0, "R7 cancel");
    pulse(4, 1, 0); settle(20); pulse(0, 1, 0); settle(300);
    // R8: sleep cuts a window, loads during sleep ignored
    expect_win(30, 1, 0, "R8 sleep cut");
    pulse(4, 1, 0); settle(30);
    rf_sleep = 1;
    #1;
    chk(!cp_fast && !fsw_gate, "R8 outputs off at sleep", cp_fast | fsw_gate, 0);
    settle(5);
    h0 = tot_hi; s0 = tot_sw;
    pulse(5, 1, 0); settle(5);
    rf_sleep = 0;
    settle(400);
    chk(tot_hi == h0 && tot_sw == s0, "R8 load in sleep ignored", tot_hi + tot_sw - h0 - s0, 0);
    chk(exp_q.size() == 0, "R1 all windows observed", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule